// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor between its normal running state and three reduced-power states. In the first of these the processor clock is stopped. In the second the main oscillator is also stopped. The third is the same as the second, with the brownout detector and the comparators switched off as well. From the current state and a few configuration inputs, the block produces one registered gating enable for each of these: the processor clock, the peripheral clocks, the main oscillator, the brownout detector, the comparators, the watchdog, the real-time clock and the internal RC oscillator.

Software asks for a state by writing a two-bit mode code. The write takes effect only while the processor is running. An interrupt that is pending and enabled ends the clock-stopped state. In the two oscillator-off states, only interrupts that are also marked wake-capable end the state. A reset ends any state. When the block wakes from an oscillator-off state, it waits in a warm-up state for a fixed number of cycles before it turns the processor clock back on. This models the time the oscillator needs to settle. The mode code clears itself on every wake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is high and after it is released, the block is in run (state code 0) with mode code 00. The processor, peripheral clock, oscillator and brownout enables are 1. The comparator, watchdog and RTC enables follow their configuration inputs. The RC enable follows the RC-is-system-clock input.
- R2: In run, a write with code 01, 10 or 11 enters idle (state 1), power-down (state 2) or total power-down (state 3) at the next clock edge. The mode code then holds the written value.
- R3: In idle, the processor clock is off and the peripheral clock and oscillator stay on. A pending interrupt that is also enabled returns the block to run at the next edge and clears the mode code to 00.
- R4: In power-down, the processor clock, peripheral clock and oscillator are off. The brownout enable is on. The comparator, watchdog and RTC enables follow their configuration inputs.
- R5: Total power-down matches power-down, except that the brownout and comparator enables are 0.
- R6: In power-down and total power-down, the RC enable is 1 only when the RC oscillator is the system clock and the RTC is enabled. In every other state, the RC enable equals the RC-is-system-clock input.
- R7: In either power-down state, a pending enabled interrupt whose bit is clear in the wake-capable mask has no effect.
- R8: In either power-down state, a pending, enabled, wake-capable interrupt moves the block to warm-up (state 4) and clears the mode code. The block then stays in warm-up for exactly OSC_WAIT cycles, with the oscillator on and the processor and peripheral clocks off. After that it returns to run with the processor clock on.
- R9: A write with code 00 in run has no effect. A write in any state other than run has no effect on the state or the mode code.
- R10: An interrupt that is pending but not enabled does not end idle.
- R11: Reset returns the block from any state to the R1 condition at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| sw_wr | input | 1 | Mode write strobe |
| sw_code | input | 2 | Requested mode: 00 none, 01 idle, 10 power-down, 11 total power-down |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enables |
| cfg_cmp_en | input | 1 | Comparators enabled by their own control |
| cfg_wdt_en | input | 1 | Watchdog enabled |
| cfg_rtc_en | input | 1 | RTC enabled |
| cfg_rc_sysclk | input | 1 | RC oscillator selected as system clock |
| pm_state | output | 3 | Current state: 0 run, 1 idle, 2 power-down, 3 total power-down, 4 warm-up |
| mode_req | output | 2 | Current mode code |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| bod_en | output | 1 | Brownout detector enable |
| cmp_en | output | 1 | Comparator enable |
| wdt_en | output | 1 | Watchdog enable |
| rtc_en | output | 1 | RTC enable |
| rco_en | output | 1 | Internal RC oscillator enable |

## Verification
The bench builds the block with OSC_WAIT = 16, four interrupt lines and a wake-capable mask of 0101. The short warm-up lets the bench check the entire warm-up window on every wake, down to the exact cycle the processor clock returns. The mask leaves lines 1 and 3 enabled but unable to wake, so the bench can show that the power-down states ignore such interrupts while idle still responds to any enabled line.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_RUN  = 3'd0,
    PM_IDLE = 3'd1,
    PM_PD   = 3'd2,
    PM_TPD  = 3'd3,
    PM_WARM = 3'd4
  } pm_state_e;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_IDLE = 2'b01;
  localparam logic [1:0] CODE_PD   = 2'b10;
  localparam logic [1:0] CODE_TPD  = 2'b11;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic bod;
    logic cmp;
    logic wdt;
    logic rtc;
    logic rco;
  } pm_gates_t;

  function automatic pm_gates_t gates_for(pm_state_e st, logic cmp_cfg,
                                          logic wdt_cfg, logic rtc_cfg,
                                          logic rc_sys);
    pm_gates_t g;
    logic      osc_off;
    osc_off = (st == PM_PD) || (st == PM_TPD);
    g.cpu   = (st == PM_RUN);
    g.per   = (st == PM_RUN) || (st == PM_IDLE);
    g.osc   = !osc_off;
    g.bod   = (st != PM_TPD);
    g.cmp   = cmp_cfg && (st != PM_TPD);
    g.wdt   = wdt_cfg;
    g.rtc   = rtc_cfg;
    g.rco   = osc_off ? (rc_sys && rtc_cfg) : rc_sys;
    return g;
  endfunction

endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int                 N_IRQ     = 8,
  parameter logic [N_IRQ-1:0]   WAKE_MASK = '1
) (
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             idle_wake,
  output logic             pd_wake
);

  logic [N_IRQ-1:0] hit;
  logic [N_IRQ-1:0] pd_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign hit[i] = irq_pend[i] & irq_en[i];
    if (WAKE_MASK[i]) begin : g_cap
      assign pd_hit[i] = hit[i];
    end else begin : g_nocap
      assign pd_hit[i] = 1'b0;
    end
  end

  assign idle_wake = |hit;
  assign pd_wake   = |pd_hit;

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int OSC_WAIT = 256
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sw_wr,
  input  logic [1:0] sw_code,
  input  logic      idle_wake,
  input  logic      pd_wake,
  output pm_state_e state_q,
  output pm_state_e state_d,
  output logic [1:0] req_q
);

  localparam int CW = $clog2(OSC_WAIT + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(OSC_WAIT - 1);

  logic [1:0]    req_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PM_RUN: begin
        if (sw_wr && (sw_code != CODE_NONE)) begin
          req_d = sw_code;
          unique case (sw_code)
            CODE_IDLE: state_d = PM_IDLE;
            CODE_PD:   state_d = PM_PD;
            default:   state_d = PM_TPD;
          endcase
        end
      end
      PM_IDLE: begin
        if (idle_wake) begin
          state_d = PM_RUN;
          req_d   = CODE_NONE;
        end
      end
      PM_PD, PM_TPD: begin
        if (pd_wake) begin
          state_d = PM_WARM;
          req_d   = CODE_NONE;
          cnt_d   = CNT_LOAD;
        end
      end
      PM_WARM: begin
        if (cnt_q == '0) state_d = PM_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        state_d = PM_RUN;
        req_d   = CODE_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_RUN;
      req_q   <= CODE_NONE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      cnt_q   <= cnt_d;
    end
  end

  // Independent count of cycles spent in warm-up, for the window check.
  logic [CW:0] warm_age;
  always_ff @(posedge clk) begin
    if (rst)                     warm_age <= '0;
    else if (state_q == PM_WARM) warm_age <= warm_age + 1'b1;
    else                         warm_age <= '0;
  end

  p_warm_len_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && $past(state_q) == PM_WARM) |-> (warm_age == (CW+1)'(OSC_WAIT)));

  p_req_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && $past(state_q) != PM_RUN) |-> (req_q == CODE_NONE));

  p_pd_from_run_r9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == PM_PD || state_q == PM_TPD || state_q == PM_IDLE) && state_q != $past(state_q))
      |-> ($past(state_q) == PM_RUN));

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_e state_d,
  input  logic      cfg_cmp_en,
  input  logic      cfg_wdt_en,
  input  logic      cfg_rtc_en,
  input  logic      cfg_rc_sysclk,
  output pm_gates_t gates_q
);

  pm_state_e eff_state;
  assign eff_state = rst ? PM_RUN : state_d;

  always_ff @(posedge clk) begin
    gates_q <= gates_for(eff_state, cfg_cmp_en, cfg_wdt_en, cfg_rtc_en, cfg_rc_sysclk);
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int               N_IRQ     = 8,
  parameter logic [N_IRQ-1:0] WAKE_MASK = 8'h0F,
  parameter int               OSC_WAIT  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic [1:0]       sw_code,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             cfg_cmp_en,
  input  logic             cfg_wdt_en,
  input  logic             cfg_rtc_en,
  input  logic             cfg_rc_sysclk,
  output logic [2:0]       pm_state,
  output logic [1:0]       mode_req,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             bod_en,
  output logic             cmp_en,
  output logic             wdt_en,
  output logic             rtc_en,
  output logic             rco_en
);

  logic      idle_wake, pd_wake;
  pm_state_e state_q, state_d;
  pm_gates_t gates_q;

  pmc_wake #(.N_IRQ(N_IRQ), .WAKE_MASK(WAKE_MASK)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .idle_wake(idle_wake),
    .pd_wake  (pd_wake)
  );

  pmc_seq #(.OSC_WAIT(OSC_WAIT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .sw_wr    (sw_wr),
    .sw_code  (sw_code),
    .idle_wake(idle_wake),
    .pd_wake  (pd_wake),
    .state_q  (state_q),
    .state_d  (state_d),
    .req_q    (mode_req)
  );

  pmc_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .state_d      (state_d),
    .cfg_cmp_en   (cfg_cmp_en),
    .cfg_wdt_en   (cfg_wdt_en),
    .cfg_rtc_en   (cfg_rtc_en),
    .cfg_rc_sysclk(cfg_rc_sysclk),
    .gates_q      (gates_q)
  );

  assign pm_state   = state_q;
  assign cpu_clk_en = gates_q.cpu;
  assign per_clk_en = gates_q.per;
  assign osc_en     = gates_q.osc;
  assign bod_en     = gates_q.bod;
  assign cmp_en     = gates_q.cmp;
  assign wdt_en     = gates_q.wdt;
  assign rtc_en     = gates_q.rtc;
  assign rco_en     = gates_q.rco;

  p_cpu_run_only_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (state_q == PM_RUN));

  p_pd_osc_off_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_PD || state_q == PM_TPD) |-> (!osc_en && !per_clk_en && !cpu_clk_en));

  p_tpd_analog_off_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_TPD) |-> (!bod_en && !cmp_en));

  p_bod_only_tpd_r5: assert property (@(posedge clk) disable iff (rst)
    !bod_en |-> (state_q == PM_TPD));

  p_warm_gates_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_WARM) |-> (osc_en && !cpu_clk_en && !per_clk_en));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

  localparam int             N_IRQ     = 4;
  localparam logic [3:0]     WAKE_MASK = 4'b0101;
  localparam int             OSC_WAIT  = 16;

  localparam int S_RUN = 0, S_IDLE = 1, S_PD = 2, S_TPD = 3, S_WARM = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             sw_wr;
  logic [1:0]       sw_code;
  logic [N_IRQ-1:0] irq_pend, irq_en;
  logic             cfg_cmp_en, cfg_wdt_en, cfg_rtc_en, cfg_rc_sysclk;
  logic [2:0]       pm_state;
  logic [1:0]       mode_req;
  logic             cpu_clk_en, per_clk_en, osc_en, bod_en, cmp_en, wdt_en, rtc_en, rco_en;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(N_IRQ), .WAKE_MASK(WAKE_MASK), .OSC_WAIT(OSC_WAIT)) u_dut (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_code(sw_code),
    .irq_pend(irq_pend), .irq_en(irq_en),
    .cfg_cmp_en(cfg_cmp_en), .cfg_wdt_en(cfg_wdt_en),
    .cfg_rtc_en(cfg_rtc_en), .cfg_rc_sysclk(cfg_rc_sysclk),
    .pm_state(pm_state), .mode_req(mode_req),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .bod_en(bod_en), .cmp_en(cmp_en), .wdt_en(wdt_en), .rtc_en(rtc_en), .rco_en(rco_en)
  );

  typedef struct {
    logic [12:0] vec;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Expected outputs from the requirements: {state, code, cpu, per, osc, bod, cmp, wdt, rtc, rco}
  function automatic logic [12:0] model(int st, logic [1:0] code);
    logic off;
    logic [7:0] g;
    off  = (st == S_PD) || (st == S_TPD);
    g[7] = (st == S_RUN);
    g[6] = (st == S_RUN) || (st == S_IDLE);
    g[5] = !off;
    g[4] = (st != S_TPD);
    g[3] = cfg_cmp_en && (st != S_TPD);
    g[2] = cfg_wdt_en;
    g[1] = cfg_rtc_en;
    g[0] = off ? (cfg_rc_sysclk && cfg_rtc_en) : cfg_rc_sysclk;
    return {3'(st), code, g};
  endfunction

  // Driver: inputs are already applied; wait for the edge, then queue the expectation.
  task automatic cyc(string tag, int st, logic [1:0] code);
    exp_item_t it;
    @(posedge clk);
    #1;
    it.vec = model(st, code);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_item_t it;
      logic [12:0] act;
      it  = exp_q.pop_front();
      act = {pm_state, mode_req, cpu_clk_en, per_clk_en, osc_en, bod_en,
             cmp_en, wdt_en, rtc_en, rco_en};
      checks++;
      if (act !== it.vec) begin
        failures++;
        $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.vec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sw_wr = 1'b0; sw_code = 2'b00;
    irq_pend = '0; irq_en = '0;
    cfg_cmp_en = 1'b1; cfg_wdt_en = 1'b1; cfg_rtc_en = 1'b0; cfg_rc_sysclk = 1'b0;

    repeat (3) cyc("R1 in reset", S_RUN, 2'b00);
    rst = 1'b0;
    cyc("R1 after reset", S_RUN, 2'b00);

    sw_wr = 1'b1; sw_code = 2'b00;
    cyc("R9 code 00 in run", S_RUN, 2'b00);
    sw_wr = 1'b0;

    sw_wr = 1'b1; sw_code = 2'b01;
    cyc("R2 enter idle", S_IDLE, 2'b01);
    sw_wr = 1'b0;
    cyc("R3 idle gates", S_IDLE, 2'b01);

    irq_pend = 4'b0001; irq_en = 4'b0000;
    cyc("R10 disabled irq in idle", S_IDLE, 2'b01);
    cyc("R10 disabled irq in idle hold", S_IDLE, 2'b01);

    sw_wr = 1'b1; sw_code = 2'b10;
    cyc("R9 write in idle", S_IDLE, 2'b01);
    sw_wr = 1'b0;

    irq_en = 4'b0010; irq_pend = 4'b0010;
    cyc("R3 non-wake-capable line wakes idle", S_RUN, 2'b00);
    irq_pend = '0; irq_en = '0;

    cfg_rc_sysclk = 1'b1;
    cyc("R6 rc in run", S_RUN, 2'b00);

    sw_wr = 1'b1; sw_code = 2'b10;
    cyc("R4 enter power-down", S_PD, 2'b10);
    sw_wr = 1'b0;
    cyc("R6 rc off without rtc in pd", S_PD, 2'b10);

    sw_wr = 1'b1; sw_code = 2'b01;
    cyc("R9 write in power-down", S_PD, 2'b10);
    sw_wr = 1'b0;

    irq_en = 4'b1111; irq_pend = 4'b0010;
    cyc("R7 line 1 ignored in pd", S_PD, 2'b10);
    irq_pend = 4'b1000;
    cyc("R7 line 3 ignored in pd", S_PD, 2'b10);
    irq_en = 4'b0000; irq_pend = 4'b0100;
    cyc("R7 disabled capable line in pd", S_PD, 2'b10);

    irq_en = 4'b0100;
    cyc("R8 wake to warm-up", S_WARM, 2'b00);
    irq_pend = '0; irq_en = '0;
    for (int i = 1; i < OSC_WAIT; i++) cyc("R8 warm-up window", S_WARM, 2'b00);
    cyc("R8 run after warm-up", S_RUN, 2'b00);

    cfg_rtc_en = 1'b1;
    cyc("R6 rtc on in run", S_RUN, 2'b00);
    sw_wr = 1'b1; sw_code = 2'b11;
    cyc("R5 enter total power-down", S_TPD, 2'b11);
    sw_wr = 1'b0;
    cyc("R5 R6 total power-down gates", S_TPD, 2'b11);

    irq_en = 4'b0001; irq_pend = 4'b0001;
    cyc("R8 wake from total power-down", S_WARM, 2'b00);
    irq_pend = '0; irq_en = '0;
    for (int i = 1; i < OSC_WAIT; i++) cyc("R8 warm-up window tpd", S_WARM, 2'b00);
    cyc("R8 run after tpd warm-up", S_RUN, 2'b00);

    cfg_cmp_en = 1'b0; cfg_wdt_en = 1'b0;
    sw_wr = 1'b1; sw_code = 2'b10;
    cyc("R4 pd with comparators and watchdog off", S_PD, 2'b10);
    sw_wr = 1'b0;
    rst = 1'b1;
    cyc("R11 reset from power-down", S_RUN, 2'b00);
    rst = 1'b0;
    cyc("R11 run after reset", S_RUN, 2'b00);

    sw_wr = 1'b1; sw_code = 2'b01;
    cyc("R2 idle again", S_IDLE, 2'b01);
    sw_wr = 1'b0;
    rst = 1'b1;
    cyc("R11 reset from idle", S_RUN, 2'b00);
    rst = 1'b0;
    cyc("R1 run after idle reset", S_RUN, 2'b00);

    @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule